// File: doc/BRIEF.md
# Multi-Cycle Memory Read Sequencer

This block is the bus-master side of a read from a memory that answers more slowly than the processor. The processor side asks for a word by raising a request for one clock together with an address. The sequencer then runs a fixed sequence on separate address, data and control lines, and for that sequence it needs no handshake back from the memory.

The sequence has four steps. First the address goes onto the address bus while the active-low read strobe stays high. Next the strobe is pulled low. The strobe then stays low through a wait window so that the memory has time to drive the data lines. Finally the strobe returns high, and on that edge the word on the data bus is registered. The registered word goes back to the processor side with a one-cycle completion pulse. With the default of one wait cycle, a read occupies four clock cycles.

While a read is in flight the sequencer reports that it is busy, and it ignores further requests. The address stays on the bus after a read until the next accepted request.

Top module: `rdseq_top`

## Requirements
- R1: A request seen while the block is idle is accepted. Busy is high from the first cycle after acceptance through the completion cycle, and the read lasts exactly 3+WAIT_CYC cycles (four by default).
- R2: In the first cycle after acceptance the address bus carries the requested address while the read strobe is still high. The bus keeps that value unchanged until the next accepted request.
- R3: The read strobe is low from the second cycle of the read for 1+WAIT_CYC consecutive cycles: one strobe cycle plus the wait window.
- R4: In every other cycle the read strobe is high, including the address cycle and the completion cycle.
- R5: The data output takes the value on the data bus at the clock edge where the strobe returns high. In the cycle after that edge a done pulse one cycle wide is high and the new word is on the data output. The data output holds the word until the next completion.
- R6: A request made while busy is high, including during the completion cycle, is ignored. The running read keeps its timing, and the address bus does not change to the ignored address.
- R7: A request held high continuously starts a new read in the cycle right after each completion cycle, so back-to-back reads are separated by one idle cycle.
- R8: After reset the strobe is high, the address bus and data output are zero, busy and done are low, and the sequencer is idle.
- R9: Reset is synchronous and active low. Asserting it in the middle of a read aborts the read: the strobe goes high and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Read request from the processor side, sampled each clock |
| req_addr_i | input | ADDR_W | Address to read, taken with an accepted request |
| busy_o | output | 1 | High while a read is in progress |
| done_o | output | 1 | One-cycle pulse when the read word is valid |
| data_o | output | DATA_W | Last word read |
| bus_addr_o | output | ADDR_W | Address bus to memory |
| bus_rd_n_o | output | 1 | Read strobe, active low |
| bus_data_i | input | DATA_W | Data bus from memory |

## Verification
The bench builds the block with a 20-bit address, a 16-bit data word and a single wait cycle, which gives the four-cycle read. These values reach both ends of the address range, where 0 and all-ones give different data patterns. The bench's responder drives valid data only in the second low-strobe cycle, so a sequencer that captures early or shortens the wait registers garbage. A continuously held request and requests that arrive during busy or completion exercise the ignore and back-to-back rules, and a reset in the middle of a read covers the abort.

// File: rtl/rdseq_pkg.sv
// Package: shared state encoding for the read sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rdseq_pkg;

    // Phases of one read transaction
    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_ADDR   = 3'd1,
        SQ_STROBE = 3'd2,
        SQ_WAIT   = 3'd3,
        SQ_FINISH = 3'd4
    } sq_state_t;

endpackage

// File: rtl/rdseq_fsm.sv
// Module: rdseq_fsm
// Sequences one read: address phase, strobe, wait window, finish.
// Assumes: WAIT_CYC >= 1; requests outside SQ_IDLE are dropped.
module rdseq_fsm
    import rdseq_pkg::*;
#(
    parameter int WAIT_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic accept_o,
    output logic capture_o,
    output logic rd_n_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

    sq_state_t        state_q, state_d;
    logic [CNT_W-1:0] wcnt_q;
    logic             wait_last;

    // Last cycle of the wait window
    assign wait_last = (wcnt_q == CNT_LAST);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:   if (req_i) state_d = SQ_ADDR;
            SQ_ADDR:   state_d = SQ_STROBE;
            SQ_STROBE: state_d = SQ_WAIT;
            SQ_WAIT:   if (wait_last) state_d = SQ_FINISH;
            SQ_FINISH: state_d = SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // Wait-window counter, cleared outside the wait phase
    always_ff @(posedge clk) begin
        if (!rst_n)                 wcnt_q <= '0;
        else if (state_q != SQ_WAIT) wcnt_q <= '0;
        else if (!wait_last)        wcnt_q <= wcnt_q + 1'b1;
    end

    // Control outputs decoded from the registered state
    assign accept_o  = (state_q == SQ_IDLE) && req_i;
    assign capture_o = (state_q == SQ_WAIT) && wait_last;
    assign rd_n_o    = !((state_q == SQ_STROBE) || (state_q == SQ_WAIT));
    assign busy_o    = (state_q != SQ_IDLE);
    assign done_o    = (state_q == SQ_FINISH);

endmodule

// File: rtl/rdseq_addr_reg.sv
// Module: rdseq_addr_reg
// Holds the address bus value; loads only on an accepted request.
// Assumes: load is a single-cycle strobe from the sequencer.
module rdseq_addr_reg #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);

    // Address register, zero after reset
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_o <= '0;
        else if (load_i) addr_o <= addr_i;
    end

endmodule

// File: rtl/rdseq_capture.sv
// Module: rdseq_capture
// Registers the memory data word at the edge where the strobe rises.
// Assumes: memory data is valid in the last wait cycle.
module rdseq_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic [DATA_W-1:0] data_o
);

    // Data holding register
    always_ff @(posedge clk) begin
        if (!rst_n)         data_o <= '0;
        else if (capture_i) data_o <= bus_data_i;
    end

endmodule

// File: rtl/rdseq_top.sv
// Module: rdseq_top
// Bus-master read sequencer for a slow memory with an active-low strobe.
// Assumes: memory drives data within WAIT_CYC cycles of strobe fall.
module rdseq_top #(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int WAIT_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_rd_n_o,
    input  logic [DATA_W-1:0] bus_data_i
);

    logic accept;
    logic capture;

    rdseq_fsm #(.WAIT_CYC(WAIT_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .accept_o  (accept),
        .capture_o (capture),
        .rd_n_o    (bus_rd_n_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    rdseq_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .addr_i (req_addr_i),
        .addr_o (bus_addr_o)
    );

    rdseq_capture #(.DATA_W(DATA_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_i  (capture),
        .bus_data_i (bus_data_i),
        .data_o     (data_o)
    );

endmodule

// File: rtl/rdseq_checker.sv
// Module: rdseq_checker
// Temporal properties of the read sequence, observed at the top ports.
// Assumes: bound to rdseq_top; reset is synchronous, active low.
module rdseq_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              bus_rd_n_o,
    input logic [ADDR_W-1:0] bus_addr_o
);

    // R2: address steady once the read has started
    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(bus_addr_o));

    // R4: strobe still high in the address cycle
    p_rd_high_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> bus_rd_n_o);

    // R3: strobe falls in the cycle after the address cycle
    p_strobe_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |=> !bus_rd_n_o);

    // R5: done comes right after the strobe rises
    p_done_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (bus_rd_n_o && !$past(bus_rd_n_o)));

    // R5: done lasts one cycle
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1: done only while busy, and busy ends after it
    p_done_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);
    p_busy_ends_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

endmodule

bind rdseq_top rdseq_checker #(.ADDR_W(ADDR_W)) u_rdseq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .bus_rd_n_o (bus_rd_n_o),
    .bus_addr_o (bus_addr_o)
);

// File: tb/rdseq_top_bench.sv
// Bench: behavioural phase model compared with the ports on every clock.
module rdseq_top_bench;

    localparam int AW   = 20;
    localparam int DW   = 16;
    localparam int WC   = 1;
    localparam int LAST = 3 + WC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          busy, done, rd_n;
    logic [DW-1:0] data;
    logic [AW-1:0] baddr;
    logic [DW-1:0] bdata;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rdseq_top #(.ADDR_W(AW), .DATA_W(DW), .WAIT_CYC(WC)) u_rdseq_top (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_addr_i(req_addr),
        .busy_o(busy), .done_o(done), .data_o(data),
        .bus_addr_o(baddr), .bus_rd_n_o(rd_n), .bus_data_i(bdata)
    );

    // Memory content as a function of address
    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return a[15:0] ^ 16'h5A3C ^ {a[19:16], 12'h000};
    endfunction

    // Slow memory responder: valid data only in the second low-strobe cycle
    logic low_seen = 1'b0;
    always @(posedge clk) low_seen <= !rd_n;
    assign bdata = (!rd_n && low_seen) ? mem_word(baddr) : 16'hDEAD;

    // Reference model
    int            ph = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (!rst_n) begin
            ph = 0; m_addr = '0; m_data = '0;
        end else if (ph == 0) begin
            if (req) begin ph = 1; m_addr = req_addr; end
        end else begin
            if (ph == LAST - 1) m_data = mem_word(m_addr);
            ph = (ph == LAST) ? 0 : ph + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cycles, act, exp);
        end
    endtask

    // Compare every output on the falling edge
    always @(negedge clk) begin
        if (cycles > 0 && !finished) begin
            chk(rst_n ? "R1 busy" : "R8 R9 busy", 32'(busy), 32'(ph != 0));
            chk(rst_n ? "R3 R4 strobe" : "R8 R9 strobe", 32'(rd_n),
                32'(!(ph >= 2 && ph <= LAST - 1)));
            chk(rst_n ? "R5 done" : "R8 R9 done", 32'(done), 32'(ph == LAST));
            chk(rst_n ? "R5 data" : "R8 data", 32'(data), 32'(m_data));
            chk(rst_n ? "R2 R6 addr" : "R8 addr", 32'(baddr), 32'(m_addr));
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic read_once(input logic [AW-1:0] a);
        req = 1'b1; req_addr = a;
        @(negedge clk);
        req = 1'b0; req_addr = ~a;
    endtask

    // Stimulus
    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 R2 R3 R5: single reads at several addresses
        read_once(20'h12345); idle(6);
        read_once(20'h00000); idle(6);
        read_once(20'hFFFFF); idle(6);
        // R6: requests during busy and during the completion cycle
        read_once(20'hABCDE);
        read_once(20'h11111);
        idle(1);
        read_once(20'h22222);
        read_once(20'h33333);
        idle(4);
        // R7: request held high gives back-to-back reads
        req = 1'b1; req_addr = 20'h0F0F0;
        idle(12);
        req = 1'b0;
        idle(6);
        // R9: reset in the middle of a read
        read_once(20'h54321); idle(1);
        rst_n = 1'b0; idle(2);
        rst_n = 1'b1; idle(6);
        read_once(20'h80001); idle(6);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #1000000;
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule